// File: doc/BRIEF.md
# Ring-Star Subnet Route Selector

This block computes the output port for a flit inside one 16-core subnet of a 64-core chip. The chip has four subnets. Each subnet has one wireless base station. Inside a subnet the cores sit on a bidirectional ring. A central hub switch has a direct link to every core and one to the base station. The same unit serves two kinds of switch, and a static input says which one it is in.

At a ring switch the unit picks one of four ports: local delivery, one step clockwise, one step counter-clockwise, or the uplink to the hub. Destinations within two ring hops, in either direction, stay on the ring. All other destinations go to the hub, and that includes every core in another subnet. At the hub the unit picks either the direct link to the destination core or the base station, which carries all traffic leaving the subnet.

The route is computed when a header flit arrives, and that header is steered in the same cycle. The route is then stored, and the data flits that follow use the stored port whatever is present on the destination inputs.

Top module: `rsr_route_unit`

## Requirements
- R1: At a ring switch, a header whose destination subnet (dest_id[5:4]) differs from node_subnet selects the hub uplink, port_sel bit 3.
- R2: At a ring switch, a header addressed to the switch's own ring position (dest_id[3:0] equal to node_pos) in its own subnet selects local delivery, port_sel bit 0.
- R3: At a ring switch, a same-subnet header whose clockwise distance ((dest_id[3:0] - node_pos) mod 16) is 1 or 2 selects clockwise, port_sel bit 1. This includes the wrap from position 15 to position 0.
- R4: At a ring switch, a same-subnet header whose counter-clockwise distance ((node_pos - dest_id[3:0]) mod 16) is 1 or 2 selects counter-clockwise, port_sel bit 2. This includes the wrap from position 0 to position 15.
- R5: At a ring switch, a same-subnet header that is more than two hops away in both directions selects the hub uplink, port_sel bit 3.
- R6: At the hub (at_hub=1), a same-subnet header selects the direct core link, port_sel bit dest_id[3:0].
- R7: At the hub, a header for another subnet selects the base station, port_sel bit 16.
- R8: A valid non-header flit (flit_vld=1, flit_head=0) selects the port chosen by the most recent header, whatever dest_id, node_pos, node_subnet and at_hub carry at that time.
- R9: While flit_vld is low, port_sel is all zero. After reset and before any header, a non-header flit also gets all zero.
- R10: port_sel never has more than one bit set, and it has exactly one bit set for every valid header.
- R11: A header that arrives while an earlier route is stored is steered by its own fresh route in that cycle, and the stored route is replaced for the flits after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_vld | input | 1 | A flit is present this cycle |
| flit_head | input | 1 | The present flit is a header |
| at_hub | input | 1 | 1 when the unit sits in the central hub switch, 0 when it sits in a ring switch |
| node_pos | input | 4 | Ring position of this switch |
| node_subnet | input | 2 | Subnet of this switch |
| dest_id | input | 6 | Destination core: subnet in [5:4], ring position in [3:0] |
| port_sel | output | 17 | One-hot output port. Ring switch: bit 0 local, bit 1 clockwise, bit 2 counter-clockwise, bit 3 hub. Hub: bits 0 to 15 are core links, bit 16 is the base station |

## Verification
Two functions can fall in the same cycle: steering a new header from the fresh computation, and holding the previous packet's route for data flits. The bench forces this overlap in two ways. It sends a header directly after data flits of a packet that went to a different port. It also sends back-to-back headers with no data flits between them. It then checks that the new header is steered to its own port in its own cycle. It also checks that the next data flit follows the new port and not the old one, while deliberately misleading destination values sit on the inputs.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
   // Port positions used at a ring switch
   localparam int RP_LOCAL   = 0;
   localparam int RP_CW      = 1;
   localparam int RP_CCW     = 2;
   localparam int RP_HUB     = 3;
   localparam int RING_PORTS = 4;
endpackage

// File: rtl/rsr_ring_dist.sv
module rsr_ring_dist #(
   parameter int POS_W = 4,
   parameter int REACH = 2
) (
   input  logic [POS_W-1:0] src_pos,
   input  logic [POS_W-1:0] dst_pos,
   output logic             is_self,
   output logic             cw_near,
   output logic             ccw_near
);
   localparam logic [POS_W-1:0] REACH_V = POS_W'(REACH);

   logic [POS_W-1:0] fwd_gap;
   logic [POS_W-1:0] back_gap;

   // the ring length is a power of two, so plain subtraction wraps mod N
   always_comb begin
      fwd_gap  = dst_pos - src_pos;
      back_gap = src_pos - dst_pos;
      is_self  = (fwd_gap == '0);
      cw_near  = !is_self && (fwd_gap  <= REACH_V);
      ccw_near = !is_self && (back_gap <= REACH_V);
   end
endmodule

// File: rtl/rsr_ring_sel.sv
module rsr_ring_sel
   import rsr_pkg::*;
#(
   parameter int PORT_W = 17,
   parameter int POS_W  = 4,
   parameter int SUB_W  = 2,
   parameter int REACH  = 2
) (
   input  logic [POS_W-1:0]  own_pos,
   input  logic [SUB_W-1:0]  own_sub,
   input  logic [POS_W-1:0]  dst_pos,
   input  logic [SUB_W-1:0]  dst_sub,
   output logic [PORT_W-1:0] sel
);
   logic self_hit, cw_hit, ccw_hit;

   rsr_ring_dist #(.POS_W(POS_W), .REACH(REACH)) u_dist (
      .src_pos  (own_pos),
      .dst_pos  (dst_pos),
      .is_self  (self_hit),
      .cw_near  (cw_hit),
      .ccw_near (ccw_hit)
   );

   always_comb begin
      sel = '0;
      if (dst_sub != own_sub) sel[RP_HUB]   = 1'b1;
      else if (self_hit)      sel[RP_LOCAL] = 1'b1;
      else if (cw_hit)        sel[RP_CW]    = 1'b1;
      else if (ccw_hit)       sel[RP_CCW]   = 1'b1;
      else                    sel[RP_HUB]   = 1'b1;
   end
endmodule

// File: rtl/rsr_hub_sel.sv
module rsr_hub_sel #(
   parameter int NODES  = 16,
   parameter int PORT_W = 17,
   parameter int POS_W  = 4,
   parameter int SUB_W  = 2
) (
   input  logic [SUB_W-1:0]  own_sub,
   input  logic [POS_W-1:0]  dst_pos,
   input  logic [SUB_W-1:0]  dst_sub,
   output logic [PORT_W-1:0] sel
);
   logic local_net;
   assign local_net = (dst_sub == own_sub);

   // one direct link per core on the ring
   for (genvar gi = 0; gi < NODES; gi++) begin : g_core_link
      assign sel[gi] = local_net && (dst_pos == POS_W'(gi));
   end
   // base station uplink sits just above the core links
   assign sel[NODES] = !local_net;
   if (PORT_W > NODES + 1) begin : g_pad
      assign sel[PORT_W-1:NODES+1] = '0;
   end
endmodule

// File: rtl/rsr_route_hold.sv
module rsr_route_hold #(
   parameter int PORT_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  logic              head,
   input  logic [PORT_W-1:0] fresh,
   output logic [PORT_W-1:0] sel
);
   logic [PORT_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           held_q <= '0;
      else if (vld && head) held_q <= fresh;
   end

   always_comb begin
      if (!vld)      sel = '0;
      else if (head) sel = fresh;
      else           sel = held_q;
   end
endmodule

// File: rtl/rsr_route_unit.sv
module rsr_route_unit
   import rsr_pkg::*;
#(
   parameter int RING_NODES = 16,
   parameter int SUBNETS    = 4,
   parameter int RING_REACH = 2,
   localparam int POS_W     = $clog2(RING_NODES),
   localparam int SUB_W     = $clog2(SUBNETS),
   localparam int DEST_W    = POS_W + SUB_W,
   localparam int PORT_W    = (RING_NODES + 1 > RING_PORTS) ? RING_NODES + 1 : RING_PORTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flit_vld,
   input  logic              flit_head,
   input  logic              at_hub,
   input  logic [POS_W-1:0]  node_pos,
   input  logic [SUB_W-1:0]  node_subnet,
   input  logic [DEST_W-1:0] dest_id,
   output logic [PORT_W-1:0] port_sel
);
   // elaboration-time parameter checks
   if ((1 << POS_W) != RING_NODES) begin : g_bad_ring
      $error("RING_NODES must be a power of two");
   end
   if ((1 << SUB_W) != SUBNETS) begin : g_bad_sub
      $error("SUBNETS must be a power of two");
   end
   if (RING_REACH < 1 || 2 * RING_REACH >= RING_NODES) begin : g_bad_reach
      $error("RING_REACH must be at least 1 and leave no tie between directions");
   end

   logic [POS_W-1:0]  dst_pos;
   logic [SUB_W-1:0]  dst_sub;
   logic [PORT_W-1:0] ring_choice, hub_choice, fresh_choice;

   assign dst_pos = dest_id[POS_W-1:0];
   assign dst_sub = dest_id[DEST_W-1:POS_W];

   rsr_ring_sel #(.PORT_W(PORT_W), .POS_W(POS_W), .SUB_W(SUB_W), .REACH(RING_REACH)) u_ring (
      .own_pos (node_pos),
      .own_sub (node_subnet),
      .dst_pos (dst_pos),
      .dst_sub (dst_sub),
      .sel     (ring_choice)
   );

   rsr_hub_sel #(.NODES(RING_NODES), .PORT_W(PORT_W), .POS_W(POS_W), .SUB_W(SUB_W)) u_hub (
      .own_sub (node_subnet),
      .dst_pos (dst_pos),
      .dst_sub (dst_sub),
      .sel     (hub_choice)
   );

   assign fresh_choice = at_hub ? hub_choice : ring_choice;

   rsr_route_hold #(.PORT_W(PORT_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (flit_vld),
      .head  (flit_head),
      .fresh (fresh_choice),
      .sel   (port_sel)
   );
endmodule

// File: rtl/rsr_route_chk.sv
module rsr_route_chk #(
   parameter int POS_W  = 4,
   parameter int SUB_W  = 2,
   parameter int DEST_W = 6,
   parameter int PORT_W = 17,
   parameter int NODES  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flit_vld,
   input logic              flit_head,
   input logic              at_hub,
   input logic [POS_W-1:0]  node_pos,
   input logic [SUB_W-1:0]  node_subnet,
   input logic [DEST_W-1:0] dest_id,
   input logic [PORT_W-1:0] port_sel
);
   logic hdr, other_net;
   assign hdr       = flit_vld && flit_head;
   assign other_net = dest_id[DEST_W-1:POS_W] != node_subnet;

   AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_sel)); // R10
   AST_HEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      hdr |-> $countones(port_sel) == 1); // R10
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !flit_vld |-> port_sel == '0); // R9
   AST_BODY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(flit_vld) && flit_vld && !flit_head) |-> $stable(port_sel)); // R8
   AST_RING_OFFNET: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr && !at_hub && other_net) |-> port_sel[3]); // R1
   AST_RING_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr && !at_hub && !other_net && dest_id[POS_W-1:0] == node_pos) |-> port_sel[0]); // R2
   AST_HUB_UPLINK: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr && at_hub && other_net) |-> port_sel[NODES]); // R7
endmodule

bind rsr_route_unit rsr_route_chk #(
   .POS_W(POS_W), .SUB_W(SUB_W), .DEST_W(DEST_W), .PORT_W(PORT_W), .NODES(RING_NODES)
) u_chk (.*);

// File: tb/sim_rsr_route_unit.sv
module sim_rsr_route_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        flit_vld, flit_head, at_hub;
   logic [3:0]  node_pos;
   logic [1:0]  node_subnet;
   logic [5:0]  dest_id;
   logic [16:0] port_sel;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2 clk = ~clk; // 250 MHz

   rsr_route_unit u0 (.*);

   function automatic logic [16:0] ref_sel(bit hub, int pos, int sub, int dst);
      logic [16:0] r = '0;
      int ds = dst / 16;
      int dp = dst % 16;
      if (hub) begin
         if (ds != sub) r[16] = 1'b1; else r[dp] = 1'b1;
      end else if (ds != sub)                                   r[3] = 1'b1;
      else if (dp == pos)                                       r[0] = 1'b1;
      else if ((pos + 1) % 16 == dp || (pos + 2) % 16 == dp)    r[1] = 1'b1;
      else if ((pos + 15) % 16 == dp || (pos + 14) % 16 == dp)  r[2] = 1'b1;
      else                                                      r[3] = 1'b1;
      return r;
   endfunction

   task automatic check(string tag, logic [16:0] exp);
      checks++;
      if (port_sel !== exp) begin
         errors++;
         $display("FAIL %s: port_sel=%b expected=%b", tag, port_sel, exp);
      end
   endtask

   // drive away from the rising edge, sample 1 ns later
   task automatic drive(bit v, bit h, bit hub, int pos, int sub, int dst);
      @(negedge clk);
      flit_vld = v; flit_head = h; at_hub = hub;
      node_pos = 4'(pos); node_subnet = 2'(sub); dest_id = 6'(dst);
      #1;
   endtask

   task automatic head_chk(string tag, bit hub, int pos, int sub, int dst);
      drive(1, 1, hub, pos, sub, dst);
      check(tag, ref_sel(hub, pos, sub, dst));
   endtask

   task automatic t_reset;
      drive(0, 0, 0, 0, 0, 0);
      check("R9 idle after reset", '0);
      drive(1, 0, 0, 5, 1, 21);
      check("R9 body before any header", '0);
      drive(0, 0, 0, 5, 1, 21);
   endtask

   task automatic t_offnet;
      head_chk("R1 other subnet at ring", 0, 4, 1, 6'd36);
      check("R1 hub bit", 17'd1 << 3);
      head_chk("R1 other subnet adjacent pos", 0, 4, 1, 6'd5);
   endtask

   task automatic t_local;
      head_chk("R2 own position", 0, 9, 2, 32 + 9);
      check("R2 local bit", 17'd1);
   endtask

   task automatic t_cw;
      head_chk("R3 cw one", 0, 3, 0, 4);
      head_chk("R3 cw two", 0, 3, 0, 5);
      check("R3 cw bit", 17'd1 << 1);
      head_chk("R3 cw wrap 15->0", 0, 15, 3, 48 + 0);
      head_chk("R3 cw wrap 14->0", 0, 14, 3, 48 + 0);
   endtask

   task automatic t_ccw;
      head_chk("R4 ccw one", 0, 7, 1, 16 + 6);
      head_chk("R4 ccw two", 0, 7, 1, 16 + 5);
      check("R4 ccw bit", 17'd1 << 2);
      head_chk("R4 ccw wrap 0->15", 0, 0, 2, 32 + 15);
      head_chk("R4 ccw wrap 1->15", 0, 1, 2, 32 + 15);
   endtask

   task automatic t_far;
      head_chk("R5 three cw", 0, 3, 0, 6);
      head_chk("R5 three ccw", 0, 3, 0, 0);
      head_chk("R5 opposite", 0, 2, 1, 16 + 10);
      check("R5 hub bit", 17'd1 << 3);
   endtask

   task automatic t_hub;
      for (int i = 0; i < 16; i++) head_chk("R6 hub core link", 1, 0, 2, 32 + i);
      head_chk("R7 hub base station", 1, 0, 2, 5);
      check("R7 bs bit", 17'd1 << 16);
      head_chk("R7 hub base station sub3", 1, 7, 2, 48 + 7);
   endtask

   task automatic t_hold;
      head_chk("R8 header cw", 0, 10, 1, 16 + 12);
      drive(1, 0, 1, 3, 0, 63);
      check("R8 body ignores inputs", 17'd1 << 1);
      drive(0, 0, 0, 10, 1, 16 + 10);
      check("R9 gap", '0);
      drive(1, 0, 0, 10, 1, 16 + 10);
      check("R8 body after gap", 17'd1 << 1);
   endtask

   task automatic t_overlap;
      // header right after body flits of a packet on another port
      head_chk("R11 first header", 1, 0, 0, 9);
      drive(1, 0, 0, 0, 0, 0);
      check("R11 body old route", 17'd1 << 9);
      head_chk("R11 new header wins", 0, 6, 0, 4);
      drive(1, 0, 1, 6, 0, 40);
      check("R11 body follows new route", 17'd1 << 2);
      // back-to-back headers
      head_chk("R11 b2b header a", 1, 0, 1, 0);
      head_chk("R11 b2b header b", 0, 5, 1, 16 + 5);
      drive(1, 0, 1, 0, 1, 0);
      check("R11 body after b2b", 17'd1);
      drive(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(4 * 20000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; flit_vld = 0; flit_head = 0; at_hub = 0;
      node_pos = '0; node_subnet = '0; dest_id = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_offnet;
      t_local;
      t_cw;
      t_ccw;
      t_far;
      t_hub;
      t_hold;
      t_overlap;
      drive(0, 0, 0, 0, 0, 0);
      check("R9 final idle", '0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule